// File: doc/BRIEF.md
# Three-Cell Series Pack Protection Controller

This block is the digital decision core of a protection circuit for a pack of three cells in series. Analog comparators outside the block turn the cell voltages and the sense-resistor voltage into flags, one set per clock. The block qualifies each fault with its own delay counter and then moves between three states. In the normal state both power switches conduct. In the over-charge state charging is blocked. In the over-current state both switches are off. It drives the enables for the charge and discharge FETs, one conditioning output per cell, and status flags for over-charge, over-current and over-discharge.

Every delay is a parameter counted in clock cycles. A condition must hold through every cycle of its delay. If it drops, its counter starts again from zero. The delay counters run only in the normal state. Over-discharge is reported only and never moves a FET.

Top module: `pack_guard`

## Requirements
- R1: While `rst_n` is low at a rising edge, the block enters the normal state, clears every delay counter, clears all conditioning outputs and `odis_flag`, and holds `chg_en`=1, `dsg_en`=1, `ochg_flag`=0, `ocur_flag`=0.
- R2: Bit i of `ochg_trip` means cell i is above its over-charge threshold. In the normal state, if any bit stays set for OCHG_DLY consecutive edges, the next edge enters over-charge: `chg_en`=0, `dsg_en`=1, `ochg_flag`=1. A gap of one cycle restarts the count.
- R3: Bit k of `isense` means the current is at or above level k+1. In the normal state, if level k stays set for its own delay (OC1_DLY, OC2_DLY or OC3_DLY) plus one edge, the block enters over-current with `chg_en`=0 and `dsg_en`=0.
- R4: `ocur_flag` is 1 exactly while the block is in over-current and `load_gone` is 0.
- R5: Over-current returns to normal at the next edge where `load_gone`=1 and `isense[0]`=0. When `lvl1_inhibit`=1, the test uses `isense[1]`=0 instead.
- R6: While `lvl1_inhibit`=1, level 1 never starts its delay and cannot cause over-current, however long it lasts.
- R7: `cell_cond[i]` goes to 1 when the block enters over-charge with cell i tripped, or while in over-charge with cell i tripped. It stays 1, even after the state is released, until an edge where `ochg_clear[i]`=1 (cell at or below its release threshold).
- R8: Over-charge returns to normal at the edge where every raised conditioning output has its `ochg_clear` bit set. That same edge clears those outputs.
- R9: Over-charge also returns to normal at any edge where `dsg_start`=1, even when the offending cell is still above its release threshold. Conditioning outputs are unaffected.
- R10: If over-current and over-charge both qualify on the same edge, the block enters over-current and sets no conditioning output.
- R11: `odis_flag` equals the OR of `odis_trip` sampled at the previous edge and never changes `chg_en` or `dsg_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ochg_trip | input | 3 | Per cell: above over-charge threshold |
| ochg_clear | input | 3 | Per cell: at or below over-charge release threshold |
| odis_trip | input | 3 | Per cell: below over-discharge threshold |
| isense | input | 3 | Current at or above level 1, 2, 3 (bit 0 = level 1) |
| load_gone | input | 1 | Load has been removed from the pack |
| dsg_start | input | 1 | Discharge has begun |
| lvl1_inhibit | input | 1 | Disables over-current level 1 |
| chg_en | output | 1 | Charge FET enable |
| dsg_en | output | 1 | Discharge FET enable |
| cell_cond | output | 3 | Per-cell conditioning outputs |
| ochg_flag | output | 1 | Over-charge state |
| ocur_flag | output | 1 | Over-current with load attached |
| odis_flag | output | 1 | Some cell below over-discharge threshold |

## Verification
Every fault condition is held for exactly its delay and then for one edge more. This separates a correct qualification from one that comes a cycle early or late. A trip that drops for one cycle before the delay expires must restart the full count. The three current levels are tried one at a time, and level 1 is also held far past its delay under the inhibit. Over-current release is tried with the load attached, with the load removed but the current still high, and with the inhibit moving the release test to level 2. Over-charge release is tried once by voltage and once by discharge start, with two cells tripped, so that the conditioning outputs are seen to outlive the state. Over-charge and over-current are made to qualify on the same edge to expose the priority.

// File: rtl/pack_guard_pkg.sv
// Shared types for the pack protection controller.
// Assumes: a single clock domain; all inputs are already synchronised.
package pack_guard_pkg;
    typedef enum logic [1:0] {
        ST_NORMAL  = 2'd0,
        ST_OVERCUR = 2'd1,
        ST_OVERCHG = 2'd2
    } guard_state_e;
endpackage

// File: rtl/pg_qual_timer.sv
// Fault qualification counter.
// Counts consecutive armed edges and saturates at DLY. 'fire' is high while the
// block is still armed and DLY armed edges have passed. Dropping 'arm' clears it.
// Assumes DLY >= 1.
module pg_qual_timer #(
    parameter int DLY = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    output logic fire
);
    localparam int CW = $clog2(DLY + 1);
    localparam logic [CW-1:0] LIMIT = CW'(DLY);

    logic [CW-1:0] cnt;

    // Count armed edges, restart on any gap, hold at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (!arm)
            cnt <= '0;
        else if (cnt != LIMIT)
            cnt <= cnt + 1'b1;
    end

    assign fire = arm && (cnt == LIMIT);

    // A qualified fault was already armed on the previous cycle (R2/R3).
    p_fire_after_arm_r2: assert property (@(posedge clk) disable iff (!rst_n)
        fire |-> $past(arm));
endmodule

// File: rtl/pg_cell_cond.sv
// Per-cell conditioning output with hysteresis.
// Set when the cell trips over-charge under control of the state machine.
// Cleared only when the cell reaches its release threshold. Set wins over clear.
module pg_cell_cond (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic cond_o
);
    // Hold the conditioning request until the cell has recovered.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cond_o <= 1'b0;
        else if (set_i)
            cond_o <= 1'b1;
        else if (clr_i)
            cond_o <= 1'b0;
    end

    // Without the release threshold the output must not drop (R7).
    p_cond_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cond_o && !clr_i) |=> cond_o);
endmodule

// File: rtl/pack_guard.sv
// Protection state machine for a three-cell series pack.
// Qualifies over-charge and three over-current levels with delay counters and
// drives the FET enables, conditioning outputs and status flags.
// Assumes comparator flags are synchronous to clk; delays are in clock cycles.
module pack_guard
    import pack_guard_pkg::*;
#(
    parameter int N_CELLS  = 3,
    parameter int OCHG_DLY = 64,
    parameter int OC1_DLY  = 200,
    parameter int OC2_DLY  = 40,
    parameter int OC3_DLY  = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_CELLS-1:0] ochg_trip,
    input  logic [N_CELLS-1:0] ochg_clear,
    input  logic [N_CELLS-1:0] odis_trip,
    input  logic [2:0]         isense,
    input  logic               load_gone,
    input  logic               dsg_start,
    input  logic               lvl1_inhibit,
    output logic               chg_en,
    output logic               dsg_en,
    output logic [N_CELLS-1:0] cell_cond,
    output logic               ochg_flag,
    output logic               ocur_flag,
    output logic               odis_flag
);
    localparam int OC_LEVELS = 3;

    guard_state_e state_q, state_d;
    logic                 in_normal;
    logic                 ochg_fire;
    logic [OC_LEVELS-1:0] oc_arm;
    logic [OC_LEVELS-1:0] oc_fire_v;
    logic                 oc_fire;
    logic                 enter_ochg;
    logic                 ocur_release;
    logic                 ochg_release;

    assign in_normal = (state_q == ST_NORMAL);

    // Over-charge qualification: any cell above threshold, counted in normal state only.
    pg_qual_timer #(.DLY(OCHG_DLY)) u_ochg_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .arm  (in_normal && (|ochg_trip)),
        .fire (ochg_fire)
    );

    // One qualification counter per current level; level 1 obeys the inhibit.
    generate
        for (genvar g = 0; g < OC_LEVELS; g++) begin : g_oc
            localparam int LVL_DLY = (g == 0) ? OC1_DLY : (g == 1) ? OC2_DLY : OC3_DLY;
            if (g == 0) begin : g_lvl1
                assign oc_arm[g] = in_normal && isense[g] && !lvl1_inhibit;
            end else begin : g_lvlx
                assign oc_arm[g] = in_normal && isense[g];
            end
            pg_qual_timer #(.DLY(LVL_DLY)) u_oc_timer (
                .clk  (clk),
                .rst_n(rst_n),
                .arm  (oc_arm[g]),
                .fire (oc_fire_v[g])
            );
        end
    endgenerate

    assign oc_fire      = |oc_fire_v;
    assign ocur_release = load_gone && !(lvl1_inhibit ? isense[1] : isense[0]);
    assign ochg_release = dsg_start || !(|(cell_cond & ~ochg_clear));

    // Next-state decision; over-current outranks over-charge.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_NORMAL:  if (oc_fire) state_d = ST_OVERCUR;
                        else if (ochg_fire) state_d = ST_OVERCHG;
            ST_OVERCUR: if (ocur_release) state_d = ST_NORMAL;
            ST_OVERCHG: if (ochg_release) state_d = ST_NORMAL;
            default:    state_d = ST_NORMAL;
        endcase
    end

    assign enter_ochg = in_normal && (state_d == ST_OVERCHG);

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_NORMAL;
        else
            state_q <= state_d;
    end

    // Conditioning outputs, one per cell.
    generate
        for (genvar c = 0; c < N_CELLS; c++) begin : g_cell
            pg_cell_cond u_cond (
                .clk   (clk),
                .rst_n (rst_n),
                .set_i ((enter_ochg || (state_q == ST_OVERCHG)) && ochg_trip[c]),
                .clr_i (ochg_clear[c]),
                .cond_o(cell_cond[c])
            );
        end
    endgenerate

    // Over-discharge is only reported, one cycle after sampling.
    always_ff @(posedge clk) begin
        if (!rst_n)
            odis_flag <= 1'b0;
        else
            odis_flag <= |odis_trip;
    end

    assign chg_en    = in_normal;
    assign dsg_en    = (state_q != ST_OVERCUR);
    assign ochg_flag = (state_q == ST_OVERCHG);
    assign ocur_flag = (state_q == ST_OVERCUR) && !load_gone;

    // Discharge is cut only after some current level was present (R3).
    p_dsg_cut_needs_current_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dsg_en) |-> $past(|isense));
    // Under the inhibit only levels 2 and 3 can cut discharge (R6).
    p_inhibit_lvl1_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(dsg_en) && $past(lvl1_inhibit)) |-> $past(isense[2] || isense[1]));
    // Over-current flag implies both switches open and a load attached (R4).
    p_ocur_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ocur_flag |-> (!dsg_en && !chg_en && !load_gone));
    // Leaving over-charge needs discharge start or a recovered cell (R8/R9).
    p_ochg_exit_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(chg_en) && $past(dsg_en)) |-> $past(dsg_start || (|ochg_clear)));
    // Simultaneous qualification resolves to over-current (R10).
    p_oc_priority_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_normal && oc_fire && ochg_fire) |=> (!dsg_en && (cell_cond == $past(cell_cond))));
    // Over-discharge follows its inputs by one edge (R11).
    p_odis_follow_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (|odis_trip) |=> odis_flag);
endmodule

// File: tb/pack_guard_tb.sv
// Bench for pack_guard: a vector table walked by one loop, then directed reset tests.
module pack_guard_tb;
    localparam int OCHG_D = 5;
    localparam int OC1_D  = 8;
    localparam int OC2_D  = 4;
    localparam int OC3_D  = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [2:0] ochg_trip = '0, ochg_clear = 3'b111, odis_trip = '0, isense = '0;
    logic load_gone = 1'b0, dsg_start = 1'b0, lvl1_inhibit = 1'b0;
    logic chg_en, dsg_en, ochg_flag, ocur_flag, odis_flag;
    logic [2:0] cell_cond;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    pack_guard #(
        .N_CELLS(3), .OCHG_DLY(OCHG_D), .OC1_DLY(OC1_D), .OC2_DLY(OC2_D), .OC3_DLY(OC3_D)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .ochg_trip(ochg_trip), .ochg_clear(ochg_clear),
        .odis_trip(odis_trip), .isense(isense), .load_gone(load_gone),
        .dsg_start(dsg_start), .lvl1_inhibit(lvl1_inhibit), .chg_en(chg_en),
        .dsg_en(dsg_en), .cell_cond(cell_cond), .ochg_flag(ochg_flag),
        .ocur_flag(ocur_flag), .odis_flag(odis_flag)
    );

    typedef struct packed {
        logic [2:0] trip;
        logic [2:0] clr;
        logic [2:0] odis;
        logic [2:0] isn;
        logic       lg;
        logic       ds;
        logic       inh;
        logic [7:0] hold;
        logic       e_chg;
        logic       e_dsg;
        logic       e_ochg;
        logic       e_ocur;
        logic       e_odis;
        logic [2:0] e_cond;
    } vec_t;

    localparam int NV = 28;
    // trip clr odis isn lg ds inh hold | chg dsg ochg ocur odis cond
    localparam vec_t VT [NV] = '{
        '{3'b000,3'b111,3'b000,3'b000,1'b0,1'b0,1'b0,8'd2, 1'b1,1'b1,1'b0,1'b0,1'b0,3'b000}, // 0  idle
        '{3'b001,3'b110,3'b000,3'b000,1'b0,1'b0,1'b0,8'd5, 1'b1,1'b1,1'b0,1'b0,1'b0,3'b000}, // 1  R2 not yet
        '{3'b000,3'b111,3'b000,3'b000,1'b0,1'b0,1'b0,8'd1, 1'b1,1'b1,1'b0,1'b0,1'b0,3'b000}, // 2  R2 gap
        '{3'b001,3'b110,3'b000,3'b000,1'b0,1'b0,1'b0,8'd5, 1'b1,1'b1,1'b0,1'b0,1'b0,3'b000}, // 3  R2 restarted
        '{3'b001,3'b110,3'b000,3'b000,1'b0,1'b0,1'b0,8'd1, 1'b0,1'b1,1'b1,1'b0,1'b0,3'b001}, // 4  R2 trips, R7
        '{3'b000,3'b110,3'b000,3'b000,1'b0,1'b0,1'b0,8'd3, 1'b0,1'b1,1'b1,1'b0,1'b0,3'b001}, // 5  R7 hysteresis
        '{3'b000,3'b111,3'b000,3'b000,1'b0,1'b0,1'b0,8'd1, 1'b1,1'b1,1'b0,1'b0,1'b0,3'b000}, // 6  R8 release
        '{3'b110,3'b001,3'b000,3'b000,1'b0,1'b0,1'b0,8'd6, 1'b0,1'b1,1'b1,1'b0,1'b0,3'b110}, // 7  R2 two cells
        '{3'b000,3'b001,3'b000,3'b000,1'b0,1'b1,1'b0,8'd1, 1'b1,1'b1,1'b0,1'b0,1'b0,3'b110}, // 8  R9 dsg start
        '{3'b000,3'b111,3'b000,3'b000,1'b0,1'b0,1'b0,8'd1, 1'b1,1'b1,1'b0,1'b0,1'b0,3'b000}, // 9  R7 clear
        '{3'b000,3'b111,3'b000,3'b001,1'b0,1'b0,1'b0,8'd8, 1'b1,1'b1,1'b0,1'b0,1'b0,3'b000}, // 10 R3 lvl1 not yet
        '{3'b000,3'b111,3'b000,3'b001,1'b0,1'b0,1'b0,8'd1, 1'b0,1'b0,1'b0,1'b1,1'b0,3'b000}, // 11 R3 lvl1, R4
        '{3'b000,3'b111,3'b000,3'b000,1'b0,1'b0,1'b0,8'd2, 1'b0,1'b0,1'b0,1'b1,1'b0,3'b000}, // 12 R5 load on
        '{3'b000,3'b111,3'b000,3'b001,1'b1,1'b0,1'b0,8'd2, 1'b0,1'b0,1'b0,1'b0,1'b0,3'b000}, // 13 R5 current high, R4
        '{3'b000,3'b111,3'b000,3'b000,1'b1,1'b0,1'b0,8'd1, 1'b1,1'b1,1'b0,1'b0,1'b0,3'b000}, // 14 R5 release
        '{3'b000,3'b111,3'b000,3'b011,1'b0,1'b0,1'b0,8'd4, 1'b1,1'b1,1'b0,1'b0,1'b0,3'b000}, // 15 R3 lvl2 not yet
        '{3'b000,3'b111,3'b000,3'b011,1'b0,1'b0,1'b0,8'd1, 1'b0,1'b0,1'b0,1'b1,1'b0,3'b000}, // 16 R3 lvl2
        '{3'b000,3'b111,3'b000,3'b000,1'b1,1'b0,1'b0,8'd1, 1'b1,1'b1,1'b0,1'b0,1'b0,3'b000}, // 17 R5
        '{3'b000,3'b111,3'b000,3'b111,1'b0,1'b0,1'b0,8'd3, 1'b0,1'b0,1'b0,1'b1,1'b0,3'b000}, // 18 R3 lvl3
        '{3'b000,3'b111,3'b000,3'b000,1'b1,1'b0,1'b0,8'd1, 1'b1,1'b1,1'b0,1'b0,1'b0,3'b000}, // 19 R5
        '{3'b000,3'b111,3'b000,3'b001,1'b0,1'b0,1'b1,8'd20,1'b1,1'b1,1'b0,1'b0,1'b0,3'b000}, // 20 R6 lvl1 ignored
        '{3'b000,3'b111,3'b000,3'b011,1'b0,1'b0,1'b1,8'd5, 1'b0,1'b0,1'b0,1'b1,1'b0,3'b000}, // 21 R6 lvl2 still works
        '{3'b000,3'b111,3'b000,3'b001,1'b1,1'b0,1'b1,8'd1, 1'b1,1'b1,1'b0,1'b0,1'b0,3'b000}, // 22 R5 release on lvl2
        '{3'b000,3'b111,3'b010,3'b000,1'b0,1'b0,1'b0,8'd1, 1'b1,1'b1,1'b0,1'b0,1'b1,3'b000}, // 23 R11
        '{3'b000,3'b111,3'b000,3'b000,1'b0,1'b0,1'b0,8'd1, 1'b1,1'b1,1'b0,1'b0,1'b0,3'b000}, // 24 R11 clears
        '{3'b001,3'b110,3'b000,3'b000,1'b0,1'b0,1'b0,8'd1, 1'b1,1'b1,1'b0,1'b0,1'b0,3'b000}, // 25 R10 lead-in
        '{3'b001,3'b110,3'b000,3'b011,1'b0,1'b0,1'b0,8'd4, 1'b1,1'b1,1'b0,1'b0,1'b0,3'b000}, // 26 R10 both armed
        '{3'b001,3'b110,3'b000,3'b011,1'b0,1'b0,1'b0,8'd1, 1'b0,1'b0,1'b0,1'b1,1'b0,3'b000}  // 27 R10 over-current wins
    };

    task automatic check(input string req, input string what, input logic [2:0] act, input logic [2:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    task automatic check_all(input string req, input logic c, input logic d, input logic oc,
                             input logic ou, input logic od, input logic [2:0] cc);
        check(req, "chg_en",    {2'b0, chg_en},    {2'b0, c});
        check(req, "dsg_en",    {2'b0, dsg_en},    {2'b0, d});
        check(req, "ochg_flag", {2'b0, ochg_flag}, {2'b0, oc});
        check(req, "ocur_flag", {2'b0, ocur_flag}, {2'b0, ou});
        check(req, "odis_flag", {2'b0, odis_flag}, {2'b0, od});
        check(req, "cell_cond", cell_cond, cc);
    endtask

    task automatic idle_inputs();
        ochg_trip = '0; ochg_clear = 3'b111; odis_trip = '0; isense = '0;
        load_gone = 1'b0; dsg_start = 1'b0; lvl1_inhibit = 1'b0;
    endtask

    initial begin
        #2;
        // R1: reset state
        repeat (2) @(posedge clk);
        #1;
        check_all("R1", 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 3'b000);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            ochg_trip = VT[i].trip; ochg_clear = VT[i].clr; odis_trip = VT[i].odis;
            isense = VT[i].isn; load_gone = VT[i].lg; dsg_start = VT[i].ds;
            lvl1_inhibit = VT[i].inh;
            repeat (int'(VT[i].hold)) @(posedge clk);
            #1;
            check_all($sformatf("vec%0d", i), VT[i].e_chg, VT[i].e_dsg, VT[i].e_ochg,
                      VT[i].e_ocur, VT[i].e_odis, VT[i].e_cond);
        end

        // R1: reset out of over-current
        @(posedge clk); #1;
        rst_n = 1'b0; idle_inputs();
        @(posedge clk); #1;
        check_all("R1", 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 3'b000);

        // R1: reset out of over-charge clears state and conditioning
        rst_n = 1'b1; ochg_trip = 3'b100; ochg_clear = 3'b011;
        repeat (OCHG_D + 1) @(posedge clk); #1;
        check_all("R2", 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 3'b100);
        rst_n = 1'b0; odis_trip = 3'b001;
        @(posedge clk); #1;
        check_all("R1", 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 3'b000);

        // R1: reset clears a partly run counter; full delay needed afterwards
        rst_n = 1'b1; odis_trip = '0; ochg_trip = 3'b010; ochg_clear = 3'b101;
        repeat (3) @(posedge clk); #1;
        rst_n = 1'b0;
        @(posedge clk); #1;
        rst_n = 1'b1;
        repeat (OCHG_D) @(posedge clk); #1;
        check("R1", "chg_en after reset+delay", {2'b0, chg_en}, 3'b001);
        @(posedge clk); #1;
        check("R2", "chg_en one edge later", {2'b0, chg_en}, 3'b000);
        check("R7", "cell_cond", cell_cond, 3'b010);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule